// File: doc/BRIEF.md
# Load-Use Interlock Controller

This block sits beside the decode stage of an in-order pipeline. It watches the instruction that has just moved into the execute stage. When that instruction is a memory load, and its destination register is a source that the decoding instruction really reads, the loaded value cannot reach that instruction in time. The controller then holds the program counter and the fetch/decode register for one cycle. In the same cycle it tells the decode/execute register to take all-zero control fields, which inserts a bubble. One cycle later the load has advanced far enough for ordinary forwarding to supply its result.

The controller also drives the flush of the fetch/decode register when a branch resolved in decode is taken. The two actions can collide. If the branch is waiting on a load, its outcome is not yet valid, so an interlock in that cycle wins and the flush is withheld. A guard register ensures that no interlock lasts longer than one cycle, even if upstream logic fails to clear the load flag. The controller is combinational apart from that guard.

Top module: `ldu_interlock`

## Requirements
- R1: An interlock is raised when `ex_is_load` is 1, `ex_dst` is nonzero, and `ex_dst` equals a source field whose use flag is 1. Source A is `id_src_a` with `id_use_a`, and source B is `id_src_b` with `id_use_b`. A match on either source is enough. This holds provided no interlock was raised in the previous cycle.
- R2: A source field whose use flag is 0 never raises an interlock, whatever its value.
- R3: A load whose destination is register 0 never raises an interlock.
- R4: When `ex_is_load` is 0 there is no interlock.
- R5: During an interlock `pc_en`=0, `ifid_en`=0 and `idex_ctrl_clr`=1. With no interlock `pc_en`=1, `ifid_en`=1 and `idex_ctrl_clr`=0.
- R6: An interlock never lasts two consecutive cycles. In the cycle after one, the outputs are in the no-interlock state even if the inputs still match.
- R7: Without an interlock, `ifid_flush` equals `id_branch_taken`.
- R8: When an interlock and a taken branch fall in the same cycle, `ifid_flush` is 0.
- R9: While `rst_n` is 0 there is no interlock and no flush, and the one-cycle guard is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ex_is_load | input | 1 | Execute-stage instruction reads data memory |
| ex_dst | input | REG_W | Destination register of the execute-stage load |
| id_src_a | input | REG_W | First source field of the decoding instruction |
| id_src_b | input | REG_W | Second source field of the decoding instruction |
| id_use_a | input | 1 | Decoding instruction reads source A |
| id_use_b | input | 1 | Decoding instruction reads source B |
| id_branch_taken | input | 1 | Branch resolved in decode is taken |
| pc_en | output | 1 | Program counter may update |
| ifid_en | output | 1 | Fetch/decode register may load |
| idex_ctrl_clr | output | 1 | Zero the control fields entering decode/execute |
| ifid_flush | output | 1 | Clear the fetch/decode register |

## Verification
The interlock and the taken-branch flush can occur in the same cycle. The bench provokes this by presenting a taken branch together with a load whose destination matches a used source. It then expects the interlock outputs with the flush held low. In the following cycle the same branch is presented against a bubble, and there the flush must appear. Each cycle is compared with a behavioural model that tracks only whether the previous cycle interlocked.

// File: rtl/ldu_pkg.sv
package ldu_pkg;
  typedef struct packed {
    logic pc_en;
    logic ifid_en;
    logic idex_clr;
    logic ifid_flush;
  } front_ctl_t;
endpackage

// File: rtl/ldu_src_cmp.sv
module ldu_src_cmp #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic             used,
  input  logic [REG_W-1:0] dst,
  output logic             hit
);
  always_comb hit = used && (src == dst);
endmodule

// File: rtl/ldu_stall_guard.sv
module ldu_stall_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_hit,
  output logic stall
);
  logic stall_q;

  // a hit is honoured only out of reset and not right after a stall
  always_comb stall = rst_n && raw_hit && !stall_q;

  always_ff @(posedge clk) begin
    if (!rst_n) stall_q <= 1'b0;
    else        stall_q <= stall;
  end
endmodule

// File: rtl/ldu_front_ctl.sv
module ldu_front_ctl
  import ldu_pkg::*;
(
  input  logic       rst_n,
  input  logic       stall,
  input  logic       branch_taken,
  output front_ctl_t ctl
);
  always_comb begin
    ctl.pc_en      = !stall;
    ctl.ifid_en    = !stall;
    ctl.idex_clr   = stall;
    // branch operands are stale while waiting on a load
    ctl.ifid_flush = rst_n && branch_taken && !stall;
  end
endmodule

// File: rtl/ldu_interlock.sv
module ldu_interlock
  import ldu_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ex_is_load,
  input  logic [REG_W-1:0] ex_dst,
  input  logic [REG_W-1:0] id_src_a,
  input  logic [REG_W-1:0] id_src_b,
  input  logic             id_use_a,
  input  logic             id_use_b,
  input  logic             id_branch_taken,
  output logic             pc_en,
  output logic             ifid_en,
  output logic             idex_ctrl_clr,
  output logic             ifid_flush
);
  localparam int NUM_SRC = 2;

  logic [NUM_SRC-1:0][REG_W-1:0] src_vec;
  logic [NUM_SRC-1:0]            use_vec;
  logic [NUM_SRC-1:0]            hit_vec;
  logic                          raw_hit;
  logic                          stall;
  front_ctl_t                    ctl;

  always_comb begin
    src_vec[0] = id_src_a;
    src_vec[1] = id_src_b;
    use_vec[0] = id_use_a;
    use_vec[1] = id_use_b;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    ldu_src_cmp #(.REG_W(REG_W)) u_cmp (
      .src  (src_vec[g]),
      .used (use_vec[g]),
      .dst  (ex_dst),
      .hit  (hit_vec[g])
    );
  end

  // register 0 is hardwired and never carries a pending load
  always_comb raw_hit = ex_is_load && (ex_dst != '0) && (|hit_vec);

  ldu_stall_guard u_guard (
    .clk     (clk),
    .rst_n   (rst_n),
    .raw_hit (raw_hit),
    .stall   (stall)
  );

  ldu_front_ctl u_front (
    .rst_n        (rst_n),
    .stall        (stall),
    .branch_taken (id_branch_taken),
    .ctl          (ctl)
  );

  always_comb begin
    pc_en         = ctl.pc_en;
    ifid_en       = ctl.ifid_en;
    idex_ctrl_clr = ctl.idex_clr;
    ifid_flush    = ctl.ifid_flush;
  end
endmodule

// File: rtl/ldu_interlock_chk.sv
module ldu_interlock_chk #(
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ex_is_load,
  input logic [REG_W-1:0] ex_dst,
  input logic [REG_W-1:0] id_src_a,
  input logic [REG_W-1:0] id_src_b,
  input logic             id_use_a,
  input logic             id_use_b,
  input logic             id_branch_taken,
  input logic             pc_en,
  input logic             ifid_en,
  input logic             idex_ctrl_clr,
  input logic             ifid_flush
);
  AST_HIT_A_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_is_load && ex_dst != '0 && id_use_a && id_src_a == ex_dst && !$past(idex_ctrl_clr))
      |-> idex_ctrl_clr); // R1
  AST_HIT_B_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_is_load && ex_dst != '0 && id_use_b && id_src_b == ex_dst && !$past(idex_ctrl_clr))
      |-> idex_ctrl_clr); // R1
  AST_UNUSED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!id_use_a && !id_use_b) |-> !idex_ctrl_clr); // R2
  AST_ZERO_DST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_dst == '0) |-> !idex_ctrl_clr); // R3
  AST_NO_LOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_is_load |-> !idex_ctrl_clr); // R4
  AST_FREEZE_FRONT: assert property (@(posedge clk) disable iff (!rst_n)
    idex_ctrl_clr |-> (!pc_en && !ifid_en)); // R5
  AST_RUN_FRONT: assert property (@(posedge clk) disable iff (!rst_n)
    !idex_ctrl_clr |-> (pc_en && ifid_en)); // R5
  AST_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    idex_ctrl_clr |=> !idex_ctrl_clr); // R6
  AST_FLUSH_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !idex_ctrl_clr |-> (ifid_flush == id_branch_taken)); // R7
  AST_FLUSH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    idex_ctrl_clr |-> !ifid_flush); // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!idex_ctrl_clr && !ifid_flush)); // R9
endmodule

bind ldu_interlock ldu_interlock_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/test_ldu_interlock.sv
module test_ldu_interlock;
  localparam int RW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ex_is_load = 1'b0;
  logic [RW-1:0] ex_dst = '0;
  logic [RW-1:0] id_src_a = '0;
  logic [RW-1:0] id_src_b = '0;
  logic          id_use_a = 1'b0;
  logic          id_use_b = 1'b0;
  logic          id_branch_taken = 1'b0;
  logic          pc_en, ifid_en, idex_ctrl_clr, ifid_flush;

  int total = 0;
  int bad = 0;
  bit prev_stall = 1'b0;

  always #4 clk = ~clk;

  ldu_interlock #(.REG_W(RW)) i_ldu_interlock (
    .clk(clk), .rst_n(rst_n), .ex_is_load(ex_is_load), .ex_dst(ex_dst),
    .id_src_a(id_src_a), .id_src_b(id_src_b), .id_use_a(id_use_a),
    .id_use_b(id_use_b), .id_branch_taken(id_branch_taken),
    .pc_en(pc_en), .ifid_en(ifid_en), .idex_ctrl_clr(idex_ctrl_clr),
    .ifid_flush(ifid_flush)
  );

  task automatic step(input bit rst, input bit ld, input int dst, input int a,
                      input int b, input bit ua, input bit ub, input bit br,
                      input string tag);
    bit hit, st, fl;
    @(negedge clk);
    rst_n = rst; ex_is_load = ld; ex_dst = dst[RW-1:0];
    id_src_a = a[RW-1:0]; id_src_b = b[RW-1:0];
    id_use_a = ua; id_use_b = ub; id_branch_taken = br;
    #2;
    hit = ld && dst != 0 && ((ua && a == dst) || (ub && b == dst));
    st  = rst && hit && !prev_stall;
    fl  = rst && br && !st;
    total++;
    if (pc_en !== !st || ifid_en !== !st || idex_ctrl_clr !== st || ifid_flush !== fl) begin
      bad++;
      $display("FAIL %s: got pc=%b ifid=%b clr=%b flush=%b expected pc=%b ifid=%b clr=%b flush=%b",
               tag, pc_en, ifid_en, idex_ctrl_clr, ifid_flush, !st, !st, st, fl);
    end
    @(posedge clk);
    #1;
    prev_stall = st;
  endtask

  initial begin
    #80000;
    bad++; total++;
    $display("FAIL watchdog: got hung expected done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R9: matching load and taken branch while reset is held
    step(0, 1, 3, 3, 0, 1, 0, 1, "R9 reset quiet");
    step(0, 1, 3, 3, 0, 1, 0, 0, "R9 reset quiet 2");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R4 idle after reset");
    // R1 source A hit, then bubble resumes
    step(1, 1, 7, 7, 2, 1, 1, 0, "R1 hit on A");
    step(1, 0, 0, 7, 2, 1, 1, 0, "R5 resume after bubble");
    // R1 source B hit
    step(1, 1, 9, 1, 9, 1, 1, 0, "R1 hit on B");
    step(1, 0, 0, 1, 9, 1, 1, 0, "R5 resume");
    // R2 unused sources
    step(1, 1, 4, 4, 4, 0, 0, 0, "R2 both unused");
    step(1, 1, 4, 4, 6, 0, 1, 0, "R2 A unused");
    step(1, 1, 4, 6, 4, 1, 0, 0, "R2 B unused");
    // R3 register zero
    step(1, 1, 0, 0, 0, 1, 1, 0, "R3 dst zero");
    // R4 non-load match
    step(1, 0, 12, 12, 12, 1, 1, 0, "R4 not a load");
    // R1 no match
    step(1, 1, 12, 11, 13, 1, 1, 0, "R1 no match");
    // R6 inputs held matching across two cycles
    step(1, 1, 31, 31, 31, 1, 1, 0, "R6 first stall");
    step(1, 1, 31, 31, 31, 1, 1, 0, "R6 no second stall");
    step(1, 1, 31, 31, 31, 1, 1, 0, "R6 third cycle stalls again");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R6 settle");
    // R7 flush without stall
    step(1, 0, 0, 0, 0, 0, 0, 1, "R7 flush alone");
    step(1, 1, 5, 6, 6, 1, 1, 1, "R7 flush with non-matching load");
    // R8 collision then branch replayed against bubble
    step(1, 1, 8, 8, 3, 1, 1, 1, "R8 stall beats flush");
    step(1, 0, 0, 8, 3, 1, 1, 1, "R7 flush after bubble");
    // reset mid-run clears guard
    step(1, 1, 2, 2, 0, 1, 0, 0, "R1 stall before reset");
    step(0, 1, 2, 2, 0, 1, 0, 0, "R9 reset during hit");
    step(1, 1, 2, 2, 0, 1, 0, 0, "R9 guard cleared");
    for (int i = 1; i < 32; i++) begin
      step(1, 1, i, (i * 7) % 32, (i * 3) % 32, i[0], i[1], i[2], "R1 sweep");
      step(1, 0, 0, 0, 0, 0, 0, i[3], "R7 sweep gap");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule